// File: doc/BRIEF.md
# Tagged I2C Command Entry Interpreter

This block is the sequencing layer of an I2C master. Software or a DMA fills an output FIFO with 32-bit words, each carrying two 16-bit command entries. Every entry pairs a 3-bit opcode with a payload byte. The interpreter unpacks the entries in order and turns each one into bit-level requests for a separate bit engine, which produces the actual bus waveforms and timing. The supported operations are a start condition with an address, a data byte, a data byte followed by a stop, and a counted receive.

Bytes received during a counted read are wrapped as 16-bit entries and packed two per word toward an input FIFO. A slave NACK sets a sticky error flag. The block then releases the bus and drops the rest of the sequence until the next start entry. A bus-busy output marks the span from a start condition to the matching stop.

Top module: `i2ct_cmd_engine`

## Requirements
- R1: An entry has its opcode in bits 10:8 and its payload byte in bits 7:0. A command word holds two entries, and bits 15:0 run before bits 31:16. Opcodes 0, 5, 6 and 7 are consumed without any bus operation.
- R2: Opcode 1 issues a start condition, then the payload as 8 write bits MSB first, then one read bit for the slave acknowledge. If the bus is already busy, the start is a repeated start and no stop comes before it.
- R3: Opcode 2 writes its payload as 8 write bits MSB first plus one acknowledge read bit, and issues no stop.
- R4: Opcode 3 writes its payload like opcode 2 and then issues a stop.
- R5: Opcode 4 reads N bytes, where N is the payload and a payload of 0 means 256. Each byte is 8 read bits followed by one master write bit. That bit is 0 (ACK) for every byte except the last, which gets 1 (NACK). A stop follows the last byte.
- R6: Each received byte becomes the entry {5'b0, 3'b100, byte}. Entries are packed two per word, with the first in bits 15:0, and a word is pushed with a one-cycle rx_push. If the count is odd, the final word carries zero in bits 31:16.
- R7: An acknowledge bit read as 1 sets nack_err and is followed by a stop. After that, entries with opcodes 2, 3 and 4 are consumed with no bus activity until an opcode 1 entry arrives. That entry clears nack_err.
- R8: bus_busy rises the cycle after a start completes and falls the cycle after a stop completes.
- R9: After reset there is no bit request and no push, bus_busy and nack_err are 0, and cmd_ready is 1.
- R10: bit_cmd codes are 0 start, 1 stop, 2 write bit and 3 read bit. bit_req and bit_cmd stay unchanged until bit_done is seen. bit_rx is sampled in the cycle where bit_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_word | input | 32 | Command word holding two entries |
| cmd_valid | input | 1 | cmd_word is valid |
| cmd_ready | output | 1 | Word accepted at this edge when valid |
| bit_req | output | 1 | A bit operation is requested |
| bit_cmd | output | 2 | Bit operation code |
| bit_tx | output | 1 | Data level for a write bit |
| bit_done | input | 1 | Bit engine finished the requested operation |
| bit_rx | input | 1 | Level sampled by a read bit |
| rx_word | output | 32 | Packed received entries |
| rx_push | output | 1 | rx_word is valid for one cycle |
| nack_err | output | 1 | Sticky slave NACK flag |
| bus_busy | output | 1 | Bus held between start and stop |

## Verification
A bit-engine and slave model in the bench replays every bit operation, rebuilds the written bytes and supplies read data. Counted reads are run with counts of 1, 2, 3, 5 and 0. These separate odd from even packing, a single-byte read whose first byte is also its last, and the 256 encoding. Directed sequences cover the following: a split write that checks the busy flag between the start and stop entries, ignored opcodes, a data-byte NACK that must discard the queued entries, an address NACK on a read, and a write followed by a repeated-start read.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int WORD_W = 32;
  localparam int ENT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 9;

  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_WSTOP = 3'd3;
  localparam logic [2:0] OP_READ  = 3'd4;

  typedef enum logic [1:0] {BIT_START = 2'd0, BIT_STOP = 2'd1,
                            BIT_WR = 2'd2, BIT_RD = 2'd3} bitop_e;

  function automatic logic [2:0] ent_op(input logic [ENT_W-1:0] e);
    return e[10:8];
  endfunction

  function automatic logic [BYTE_W-1:0] ent_byte(input logic [ENT_W-1:0] e);
    return e[7:0];
  endfunction

  // a zero count stands for the full 256 bytes
  function automatic logic [CNT_W-1:0] rd_count(input logic [BYTE_W-1:0] p);
    return (p == '0) ? CNT_W'(256) : {1'b0, p};
  endfunction

  function automatic logic [ENT_W-1:0] rx_entry(input logic [BYTE_W-1:0] b);
    return {5'b0, OP_READ, b};
  endfunction
endpackage

// File: rtl/i2ct_unpack.sv
module i2ct_unpack
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              ent_take,
  output logic              ent_valid,
  output logic [ENT_W-1:0]  ent
);
  logic [WORD_W-1:0] word_q;
  logic              full_q, hi_q;

  assign cmd_ready = !full_q;
  assign ent_valid = full_q;
  assign ent       = hi_q ? word_q[WORD_W-1:ENT_W] : word_q[ENT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
      hi_q   <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      word_q <= cmd_word;
      full_q <= 1'b1;
      hi_q   <= 1'b0;
    end else if (ent_take) begin
      if (hi_q) begin
        full_q <= 1'b0;
        hi_q   <= 1'b0;
      end else begin
        hi_q <= 1'b1;
      end
    end
  end

  // R1: a loaded word is presented low entry first and blocks the next load
  p_load_low_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (ent_valid && !cmd_ready && ent == $past(cmd_word[ENT_W-1:0])));
endmodule

// File: rtl/i2ct_rx_pack.sv
module i2ct_rx_pack
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_last,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_push
);
  logic [ENT_W-1:0] low_q;
  logic             have_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q      <= '0;
      have_low_q <= 1'b0;
      rx_word    <= '0;
      rx_push    <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (byte_stb) begin
        if (have_low_q) begin
          rx_word    <= {rx_entry(byte_in), low_q};
          rx_push    <= 1'b1;
          have_low_q <= 1'b0;
        end else if (byte_last) begin
          rx_word <= {{ENT_W{1'b0}}, rx_entry(byte_in)};
          rx_push <= 1'b1;
        end else begin
          low_q      <= rx_entry(byte_in);
          have_low_q <= 1'b1;
        end
      end
    end
  end

  // R6: a push is a single-cycle strobe
  p_push_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
  // R6: the final byte of a read never stays parked in the low half
  p_flush_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_last) |=> (rx_push && !have_low_q));
endmodule

// File: rtl/i2ct_seq.sv
module i2ct_seq
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_valid,
  input  logic [ENT_W-1:0]  ent,
  output logic              ent_take,
  output logic              bit_req,
  output bitop_e            bit_cmd,
  output logic              bit_tx,
  input  logic              bit_done,
  input  logic              bit_rx,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_last,
  output logic              nack_err,
  output logic              bus_busy
);
  typedef enum logic [2:0] {S_FETCH, S_START, S_WBIT, S_WACK,
                            S_RBIT, S_MACK, S_STOP} st_e;
  st_e               st;
  logic [BYTE_W-1:0] sh;
  logic [2:0]        bcnt;
  logic [CNT_W-1:0]  rem;
  logic              stop_after, skip;
  logic [2:0]        op;
  logic              last_byte;

  assign op        = ent_op(ent);
  assign last_byte = (rem == CNT_W'(1));
  assign ent_take  = (st == S_FETCH) && ent_valid;
  assign bit_req   = (st != S_FETCH);
  assign byte_stb  = (st == S_MACK) && bit_done;
  assign byte_out  = sh;
  assign byte_last = last_byte;

  always_comb begin
    bit_cmd = BIT_START;
    bit_tx  = 1'b0;
    case (st)
      S_STOP:  bit_cmd = BIT_STOP;
      S_WBIT:  begin bit_cmd = BIT_WR; bit_tx = sh[BYTE_W-1]; end
      S_WACK:  bit_cmd = BIT_RD;
      S_RBIT:  bit_cmd = BIT_RD;
      S_MACK:  begin bit_cmd = BIT_WR; bit_tx = last_byte; end
      default: bit_cmd = BIT_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FETCH; sh <= '0; bcnt <= '0; rem <= '0;
      stop_after <= 1'b0; skip <= 1'b0; nack_err <= 1'b0; bus_busy <= 1'b0;
    end else begin
      case (st)
        S_FETCH: if (ent_valid) begin
          if (op == OP_START) begin
            sh <= ent_byte(ent); nack_err <= 1'b0; skip <= 1'b0;
            stop_after <= 1'b0; st <= S_START;
          end else if ((op == OP_WRITE || op == OP_WSTOP) && !skip) begin
            sh <= ent_byte(ent); stop_after <= (op == OP_WSTOP);
            bcnt <= 3'd7; st <= S_WBIT;
          end else if (op == OP_READ && !skip) begin
            rem <= rd_count(ent_byte(ent)); bcnt <= 3'd7; st <= S_RBIT;
          end
        end
        S_START: if (bit_done) begin
          bus_busy <= 1'b1; bcnt <= 3'd7; st <= S_WBIT;
        end
        S_WBIT: if (bit_done) begin
          sh <= {sh[BYTE_W-2:0], 1'b0};
          if (bcnt == 3'd0) st <= S_WACK;
          else bcnt <= bcnt - 3'd1;
        end
        S_WACK: if (bit_done) begin
          if (bit_rx) begin
            nack_err <= 1'b1; skip <= 1'b1; st <= S_STOP;
          end else begin
            st <= stop_after ? S_STOP : S_FETCH;
          end
        end
        S_RBIT: if (bit_done) begin
          sh <= {sh[BYTE_W-2:0], bit_rx};
          if (bcnt == 3'd0) st <= S_MACK;
          else bcnt <= bcnt - 3'd1;
        end
        S_MACK: if (bit_done) begin
          rem <= rem - CNT_W'(1);
          bcnt <= 3'd7;
          st <= last_byte ? S_STOP : S_RBIT;
        end
        S_STOP: if (bit_done) begin
          bus_busy <= 1'b0; st <= S_FETCH;
        end
        default: st <= S_FETCH;
      endcase
    end
  end

  // R10: a pending request holds its code until the engine finishes
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !bit_done) |=> (bit_req && $stable(bit_cmd)));
  // R8: busy follows start and stop completion
  p_busy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && bit_done && bit_cmd == BIT_START) |=> bus_busy);
  p_busy_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && bit_done && bit_cmd == BIT_STOP) |=> !bus_busy);
  // R7: a NACKed acknowledge raises the flag and heads for a stop
  p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WACK && bit_done && bit_rx) |=> (nack_err && bit_cmd == BIT_STOP));
  // R5: the last received byte is followed by a stop
  p_last_then_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_last) |=> (bit_req && bit_cmd == BIT_STOP));
endmodule

// File: rtl/i2ct_cmd_engine.sv
module i2ct_cmd_engine
  import i2ct_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cmd_word,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  output logic        bit_req,
  output logic [1:0]  bit_cmd,
  output logic        bit_tx,
  input  logic        bit_done,
  input  logic        bit_rx,
  output logic [31:0] rx_word,
  output logic        rx_push,
  output logic        nack_err,
  output logic        bus_busy
);
  logic              ent_valid, ent_take;
  logic [ENT_W-1:0]  ent;
  bitop_e            cmd_e;
  logic              byte_stb, byte_last;
  logic [BYTE_W-1:0] byte_val;

  assign bit_cmd = cmd_e;

  i2ct_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .ent_take(ent_take), .ent_valid(ent_valid), .ent(ent)
  );

  i2ct_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent(ent), .ent_take(ent_take),
    .bit_req(bit_req), .bit_cmd(cmd_e), .bit_tx(bit_tx), .bit_done(bit_done),
    .bit_rx(bit_rx), .byte_stb(byte_stb), .byte_out(byte_val), .byte_last(byte_last),
    .nack_err(nack_err), .bus_busy(bus_busy)
  );

  i2ct_rx_pack u_pack (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_in(byte_val),
    .byte_last(byte_last), .rx_word(rx_word), .rx_push(rx_push)
  );
endmodule

// File: tb/i2ct_cmd_engine_bench.sv
module i2ct_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready, bit_req, bit_tx, rx_push, nack_err, bus_busy;
  logic [1:0]  bit_cmd;
  logic        bit_done = 1'b0, bit_rx = 1'b0;
  logic [31:0] rx_word;

  always #10 clk = ~clk;

  i2ct_cmd_engine u_i2ct_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .bit_req(bit_req), .bit_cmd(bit_cmd), .bit_tx(bit_tx),
    .bit_done(bit_done), .bit_rx(bit_rx), .rx_word(rx_word), .rx_push(rx_push),
    .nack_err(nack_err), .bus_busy(bus_busy)
  );

  int checks = 0, fails = 0, cycles = 0;
  int starts, stops, ops, proto, wb_n, macks, rxn, rdbits;
  int nack_at = -1;
  logic [7:0]  wb [0:15];
  logic        mack [0:299];
  logic [31:0] rxw [0:199];
  int   sl_pos, sl_k;
  logic sl_addr, sl_read;
  logic [7:0] sl_sh;

  function automatic logic [7:0] rd_byte(input int k);
    return 8'(8'h3C + k * 7);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    starts = 0; stops = 0; ops = 0; proto = 0; wb_n = 0; macks = 0; rxn = 0; rdbits = 0;
  endtask

  // bit engine and slave model; one operation, then one idle cycle
  always @(negedge clk) begin
    logic [7:0] t;
    if (!rst_n) begin
      bit_done = 1'b0; sl_pos = 0; sl_k = 0; sl_addr = 1'b0; sl_read = 1'b0; sl_sh = '0;
    end else if (bit_done) begin
      bit_done = 1'b0;
    end else if (bit_req) begin
      ops++;
      bit_rx = 1'b0;
      case (bit_cmd)
        2'd0: begin starts++; sl_pos = 0; sl_k = 0; sl_addr = 1'b1; sl_read = 1'b0; end
        2'd1: stops++;
        2'd2: if (sl_pos < 8) begin
                if (sl_read) proto++;
                sl_sh = {sl_sh[6:0], bit_tx}; sl_pos++;
              end else begin
                if (!sl_read) proto++;
                mack[macks] = bit_tx; macks++; sl_k++; sl_pos = 0;
              end
        default: if (sl_pos < 8) begin
                if (!sl_read) proto++;
                t = rd_byte(sl_k); bit_rx = t[7 - sl_pos]; rdbits++; sl_pos++;
              end else begin
                if (sl_read) proto++;
                bit_rx = (wb_n == nack_at);
                wb[wb_n] = sl_sh;
                if (sl_addr && !bit_rx) sl_read = sl_sh[0];
                wb_n++; sl_addr = 1'b0; sl_pos = 0;
              end
      endcase
      bit_done = 1'b1;
    end
  end

  always @(negedge clk) if (rst_n && rx_push) begin
    rxw[rxn] = rx_word; rxn++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk); cmd_word = w; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic quiet();
    int q = 0;
    while (q < 40) begin @(negedge clk); q = bit_req ? 0 : q + 1; end
  endtask

  typedef struct packed { logic [6:0] addr; logic [7:0] cnt; logic [8:0] nbytes; } rvec_t;
  localparam rvec_t RV [5] = '{
    '{7'h50, 8'd1, 9'd1}, '{7'h21, 8'd2, 9'd2}, '{7'h33, 8'd3, 9'd3},
    '{7'h7F, 8'd5, 9'd5}, '{7'h0A, 8'd0, 9'd256}};

  initial begin
    clr_log();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 req", bit_req, 0); chk("R9 push", rx_push, 0);
    chk("R9 busy", bus_busy, 0); chk("R9 nack", nack_err, 0); chk("R9 ready", cmd_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 R6 counted reads from the vector table
    for (int i = 0; i < 5; i++) begin
      int n, bad;
      clr_log();
      n = int'(RV[i].nbytes);
      send({16'h0400 | {8'h0, RV[i].cnt}, 16'h0100 | {8'h0, RV[i].addr, 1'b1}});
      quiet();
      chk("R2 read addr", {24'h0, wb[0]}, {24'h0, RV[i].addr, 1'b1});
      chk("R5 starts", starts, 1); chk("R5 stops", stops, 1);
      chk("R5 byte count", macks, n); chk("R10 protocol", proto, 0);
      bad = 0;
      for (int k = 0; k < n; k++) if (mack[k] !== (k == n - 1)) bad++;
      chk("R5 ack pattern", bad, 0);
      chk("R6 words", rxn, (n + 1) / 2);
      bad = 0;
      for (int w = 0; w < (n + 1) / 2; w++) begin
        logic [31:0] e;
        e[15:0]  = {8'h04, rd_byte(2 * w)};
        e[31:16] = (2 * w + 1 < n) ? {8'h04, rd_byte(2 * w + 1)} : 16'h0;
        if (rxw[w] !== e) begin bad++; $display("FAIL R6 word %0d act=%h exp=%h", w, rxw[w], e); end
      end
      chk("R6 word contents", bad, 0);
      chk("R8 idle after read", bus_busy, 0);
    end

    // R1 ignored opcodes
    clr_log();
    send(32'h0000_0655); quiet();
    chk("R1 ignored ops", ops, 0);
    chk("R1 ready again", cmd_ready, 1);

    // R2 R3 R8 write split around busy, R4 stop
    clr_log();
    send(32'h02C3_0190); quiet();
    chk("R8 busy held", bus_busy, 1);
    chk("R3 no stop", stops, 0);
    send(32'h0344_0211); quiet();
    chk("R4 stop", stops, 1); chk("R8 idle", bus_busy, 0);
    chk("R2 addr byte", wb[0], 8'h90); chk("R3 byte1", wb[1], 8'hC3);
    chk("R3 byte2", wb[2], 8'h11); chk("R4 byte3", wb[3], 8'h44);
    chk("R3 ops", ops, 1 + 4 * 9 + 1); chk("R10 protocol w", proto, 0);

    // R7 data NACK drops the queued entries
    clr_log(); nack_at = 1;
    send(32'h02AA_0190); send(32'h03CC_02BB); quiet();
    chk("R7 nack flag", nack_err, 1); chk("R7 stop", stops, 1);
    chk("R7 bytes sent", wb_n, 2); chk("R7 ops", ops, 20);
    clr_log(); nack_at = -1;
    send(32'h0311_0190); quiet();
    chk("R7 flag cleared", nack_err, 0); chk("R7 resume bytes", wb_n, 2);

    // R7 address NACK on read
    clr_log(); nack_at = 0;
    send(32'h0403_0145); quiet();
    chk("R7 addr nack", nack_err, 1); chk("R7 no read bits", rdbits, 0);
    chk("R7 no push", rxn, 0); chk("R7 addr stop", stops, 1);

    // R2 repeated start
    clr_log(); nack_at = -1;
    send(32'h025A_0130); send(32'h0402_0131); quiet();
    chk("R2 two starts", starts, 2); chk("R2 one stop", stops, 1);
    chk("R2 rs addr", wb[2], 8'h31); chk("R6 rs words", rxn, 1);
    chk("R6 rs data", rxw[0], {8'h04, rd_byte(1), 8'h04, rd_byte(0)});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule